// File: doc/BRIEF.md
# Time Alarm Comparator and Interrupt Flag Collector

This block sits beside a real-time clock engine. It compares the current seconds, minutes and hours against three alarm values. Any alarm value whose two top bits are both 1 counts as a wildcard for that field. When the clock engine reports a finished update, the block checks the comparison once. A full match raises the alarm flag.

Two more event sources also feed sticky flags: a periodic pulse and the update-finished pulse itself. The three flags and a summary bit form one 8-bit flag register. The host reads that register, and the read clears it. An active-low interrupt line follows the summary bit. Each source has its own enable, and the enables gate only the summary bit and the interrupt line. The flags themselves latch whether or not their enable is set.

Top module: `alarm_irq_unit`

## Requirements
- R1: After reset the flag register reads 0x00 and `irq_n` is 1.
- R2: When all three time fields equal their alarm values and `update_done` is high, bit 5 (alarm flag) of `flag_reg` is 1 from the next clock edge.
- R3: An alarm value whose bits 7 and 6 are both 1 matches any current value of that field. A value with only one of those bits set is compared exactly.
- R4: If any single field differs from a non-wildcard alarm value, an update does not set bit 5.
- R5: Without an `update_done` pulse, bit 5 is never set, even while all fields match.
- R6: A `periodic_tick` pulse sets bit 6, and an `update_done` pulse sets bit 4, one clock later.
- R7: A flag sets and stays set when its enable is 0. While every enable of the set flags is 0, bit 7 stays 0 and `irq_n` stays 1.
- R8: Bit 7 is 1 exactly when some flag in bits 6..4 is set together with its enable (bit 6 with `en_periodic`, bit 5 with `en_alarm`, bit 4 with `en_update`). `irq_n` is the inverse of bit 7.
- R9: A cycle with `flag_rd` high and no event makes the whole register read 0x00 from the next clock edge.
- R10: An event that arrives in the same cycle as `flag_rd` leaves its flag set after the clear.
- R11: Bits 3..0 of `flag_reg` always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cur_sec | input | 8 | Current seconds from the clock engine |
| cur_min | input | 8 | Current minutes from the clock engine |
| cur_hr | input | 8 | Current hours from the clock engine |
| alm_sec | input | 8 | Seconds alarm value (wildcard when bits 7:6 are 11) |
| alm_min | input | 8 | Minutes alarm value (wildcard when bits 7:6 are 11) |
| alm_hr | input | 8 | Hours alarm value (wildcard when bits 7:6 are 11) |
| periodic_tick | input | 1 | One-cycle periodic event pulse |
| update_done | input | 1 | One-cycle pulse when a time update has finished |
| en_periodic | input | 1 | Enables the periodic flag toward the interrupt |
| en_alarm | input | 1 | Enables the alarm flag toward the interrupt |
| en_update | input | 1 | Enables the update flag toward the interrupt |
| flag_rd | input | 1 | Host read strobe for the flag register; clears it at the clock edge |
| flag_reg | output | 8 | {summary, periodic, alarm, update, 4'b0} |
| irq_n | output | 1 | Active-low interrupt request |

## Verification
The properties assume that `periodic_tick` and `update_done` are single-cycle strobes. They also assume that the time fields are stable in the cycle where `update_done` is high. The stimulus drives every input on the falling edge and raises each strobe for one cycle only. It changes the time and alarm values only while no strobe is active. The properties also assume no events during the two cycles after reset is released. To keep to that, the bench waits several idle cycles after reset before it sends any pulse.

// File: rtl/alarm_irq_pkg.sv
`timescale 1ns/1ps
package alarm_irq_pkg;
  localparam int unsigned FIELD_W  = 8;
  localparam int unsigned N_FIELDS = 3;
  localparam int unsigned N_SRC    = 3;
  localparam int unsigned REG_W    = 8;
  localparam int unsigned WILD_W   = 2;
  localparam int unsigned PAD_W    = REG_W - 1 - N_SRC;

  // Source order inside the flag vector; flag bit position = PAD_W + index
  typedef enum logic [1:0] {
    SRC_UPDATE   = 2'd0,
    SRC_ALARM    = 2'd1,
    SRC_PERIODIC = 2'd2
  } src_e;
endpackage

// File: rtl/alarm_rst_sync.sv
`timescale 1ns/1ps
module alarm_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb sync_d = {sync_q[STAGES-2:0], 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_n_sync = sync_q[STAGES-1];
endmodule

// File: rtl/alarm_cmp.sv
`timescale 1ns/1ps
module alarm_cmp #(
  parameter int unsigned FIELD_W  = 8,
  parameter int unsigned N_FIELDS = 3,
  parameter int unsigned WILD_W   = 2
) (
  input  logic [N_FIELDS*FIELD_W-1:0] cur_bus,
  input  logic [N_FIELDS*FIELD_W-1:0] alm_bus,
  output logic                        all_match
);
  logic [N_FIELDS-1:0] field_ok;

  for (genvar f = 0; f < N_FIELDS; f++) begin : g_field
    logic [FIELD_W-1:0] cur_f;
    logic [FIELD_W-1:0] alm_f;
    logic               wild;
    assign cur_f = cur_bus[f*FIELD_W +: FIELD_W];
    assign alm_f = alm_bus[f*FIELD_W +: FIELD_W];
    // top WILD_W bits all ones -> field always matches
    assign wild  = &alm_f[FIELD_W-1 -: WILD_W];
    assign field_ok[f] = wild | (alm_f == cur_f);
  end

  assign all_match = &field_ok;
endmodule

// File: rtl/alarm_flag_bank.sv
`timescale 1ns/1ps
module alarm_flag_bank #(
  parameter int unsigned N_SRC = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_SRC-1:0] evt,
  input  logic             clr,
  output logic [N_SRC-1:0] flags
);
  for (genvar s = 0; s < N_SRC; s++) begin : g_flag
    logic q;
    logic d;
    logic ce;

    always_comb begin
      ce = clr | evt[s];
      // an event in the clearing cycle wins over the clear
      d  = evt[s] | (q & ~clr);
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  q <= 1'b0;
      else if (ce) q <= d;
    end

    assign flags[s] = q;
  end
endmodule

// File: rtl/alarm_irq_unit.sv
`timescale 1ns/1ps
module alarm_irq_unit
  import alarm_irq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [FIELD_W-1:0] cur_sec,
  input  logic [FIELD_W-1:0] cur_min,
  input  logic [FIELD_W-1:0] cur_hr,
  input  logic [FIELD_W-1:0] alm_sec,
  input  logic [FIELD_W-1:0] alm_min,
  input  logic [FIELD_W-1:0] alm_hr,
  input  logic             periodic_tick,
  input  logic             update_done,
  input  logic             en_periodic,
  input  logic             en_alarm,
  input  logic             en_update,
  input  logic             flag_rd,
  output logic [REG_W-1:0] flag_reg,
  output logic             irq_n
);
  logic                        rst_q;
  logic [N_FIELDS*FIELD_W-1:0] cur_bus;
  logic [N_FIELDS*FIELD_W-1:0] alm_bus;
  logic                        alarm_hit;
  logic [N_SRC-1:0]            evt;
  logic [N_SRC-1:0]            en_vec;
  logic [N_SRC-1:0]            flags;
  logic                        any_irq;

  alarm_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_q)
  );

  assign cur_bus = {cur_hr, cur_min, cur_sec};
  assign alm_bus = {alm_hr, alm_min, alm_sec};

  alarm_cmp #(
    .FIELD_W  (FIELD_W),
    .N_FIELDS (N_FIELDS),
    .WILD_W   (WILD_W)
  ) u_cmp (
    .cur_bus   (cur_bus),
    .alm_bus   (alm_bus),
    .all_match (alarm_hit)
  );

  always_comb begin
    evt                = '0;
    evt[SRC_UPDATE]    = update_done;
    evt[SRC_ALARM]     = update_done & alarm_hit;
    evt[SRC_PERIODIC]  = periodic_tick;
    en_vec             = '0;
    en_vec[SRC_UPDATE]   = en_update;
    en_vec[SRC_ALARM]    = en_alarm;
    en_vec[SRC_PERIODIC] = en_periodic;
  end

  alarm_flag_bank #(.N_SRC(N_SRC)) u_flags (
    .clk   (clk),
    .rst_n (rst_q),
    .evt   (evt),
    .clr   (flag_rd),
    .flags (flags)
  );

  assign any_irq  = |(flags & en_vec);
  assign flag_reg = {any_irq, flags, {PAD_W{1'b0}}};
  assign irq_n    = ~any_irq;
endmodule

// File: rtl/alarm_irq_checker.sv
`timescale 1ns/1ps
module alarm_irq_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       periodic_tick,
  input logic       update_done,
  input logic       en_periodic,
  input logic       en_alarm,
  input logic       en_update,
  input logic       flag_rd,
  input logic [7:0] flag_reg,
  input logic       irq_n
);
  assert_alarm_needs_update_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!update_done && !flag_reg[5]) |=> !flag_reg[5]);

  assert_periodic_sets_R6: assert property (@(posedge clk) disable iff (!rst_n)
    periodic_tick |=> flag_reg[6]);

  assert_update_sets_R6: assert property (@(posedge clk) disable iff (!rst_n)
    update_done |=> flag_reg[4]);

  assert_flag_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!flag_rd && flag_reg[6]) |=> flag_reg[6]);

  assert_summary_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_reg[7] == |(flag_reg[6:4] & {en_periodic, en_alarm, en_update}))
      && (irq_n == !flag_reg[7]));

  assert_read_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_rd && !periodic_tick && !update_done) |=> (flag_reg[6:4] == 3'b000));

  assert_event_survives_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_rd && update_done) |=> flag_reg[4]);

  assert_low_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
    flag_reg[3:0] == 4'h0);
endmodule

bind alarm_irq_unit alarm_irq_checker u_chk (
  .clk           (clk),
  .rst_n         (rst_q),
  .periodic_tick (periodic_tick),
  .update_done   (update_done),
  .en_periodic   (en_periodic),
  .en_alarm      (en_alarm),
  .en_update     (en_update),
  .flag_rd       (flag_rd),
  .flag_reg      (flag_reg),
  .irq_n         (irq_n)
);

// File: tb/alarm_irq_unit_bench.sv
`timescale 1ns/1ps
module alarm_irq_unit_bench;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [7:0] cur_sec, cur_min, cur_hr;
  logic [7:0] alm_sec, alm_min, alm_hr;
  logic       periodic_tick, update_done;
  logic       en_periodic, en_alarm, en_update;
  logic       flag_rd;
  logic [7:0] flag_reg;
  logic       irq_n;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  logic [23:0] ct, at;
  logic        ex;

  always #5 clk = ~clk;

  alarm_irq_unit u_alarm_irq_unit (
    .clk(clk), .rst_n(rst_n),
    .cur_sec(cur_sec), .cur_min(cur_min), .cur_hr(cur_hr),
    .alm_sec(alm_sec), .alm_min(alm_min), .alm_hr(alm_hr),
    .periodic_tick(periodic_tick), .update_done(update_done),
    .en_periodic(en_periodic), .en_alarm(en_alarm), .en_update(en_update),
    .flag_rd(flag_rd), .flag_reg(flag_reg), .irq_n(irq_n)
  );

  // {cur hh:mm:ss, alarm hh:mm:ss, expected alarm flag}
  localparam int NV = 9;
  localparam logic [48:0] VEC [NV] = '{
    {24'h123045, 24'h123045, 1'b1},   // R2 exact
    {24'h123045, 24'h123046, 1'b0},   // R4 seconds differ
    {24'h123045, 24'h123145, 1'b0},   // R4 minutes differ
    {24'h123045, 24'h133045, 1'b0},   // R4 hours differ
    {24'h123045, 24'hC03045, 1'b1},   // R3 hours wildcard
    {24'h235959, 24'hFFFFFF, 1'b1},   // R3 all wildcard
    {24'h070000, 24'h07C500, 1'b1},   // R3 minutes wildcard
    {24'h070000, 24'h800000, 1'b0},   // R3 only bit 7 set
    {24'h070000, 24'h074000, 1'b0}    // R3 only bit 6 set
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic pulse(input bit per, input bit upd, input bit rd);
    @(negedge clk);
    periodic_tick = per; update_done = upd; flag_rd = rd;
    @(negedge clk);
    periodic_tick = 1'b0; update_done = 1'b0; flag_rd = 1'b0;
  endtask

  task automatic clear_flags();
    pulse(1'b0, 1'b0, 1'b1);
  endtask

  initial begin
    rst_n = 1'b0;
    {cur_hr, cur_min, cur_sec} = 24'h0;
    {alm_hr, alm_min, alm_sec} = 24'h010101;
    periodic_tick = 0; update_done = 0; flag_rd = 0;
    en_periodic = 0; en_alarm = 0; en_update = 0;
    repeat (3) @(negedge clk);
    chk("R1 reset flags", flag_reg, 8'h00);
    chk("R1 reset irq", {7'd0, irq_n}, 8'h01);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk("R1 after release", flag_reg, 8'h00);

    // table walk: alarm enabled only
    en_alarm = 1'b1;
    for (int i = 0; i < NV; i++) begin
      {ct, at, ex} = VEC[i];
      @(negedge clk);
      {cur_hr, cur_min, cur_sec} = ct;
      {alm_hr, alm_min, alm_sec} = at;
      pulse(1'b0, 1'b1, 1'b0);
      chk($sformatf("R2/R3/R4 vec%0d flags", i), flag_reg,
          {ex, 1'b0, ex, 1'b1, 4'h0});
      chk($sformatf("R8 vec%0d irq", i), {7'd0, irq_n}, {7'd0, ~ex});
      clear_flags();
    end
    chk("R9 cleared after table", flag_reg, 8'h00);

    // R5: match held without update
    {cur_hr, cur_min, cur_sec} = 24'h101010;
    {alm_hr, alm_min, alm_sec} = 24'h101010;
    repeat (4) @(negedge clk);
    chk("R5 no update no alarm", flag_reg, 8'h00);

    // R6 periodic only
    pulse(1'b1, 1'b0, 1'b0);
    chk("R6 periodic flag", flag_reg, 8'h40);
    clear_flags();
    // R6 update with mismatch
    alm_sec = 8'h11;
    pulse(1'b0, 1'b1, 1'b0);
    chk("R6 update flag", flag_reg, 8'h10);
    clear_flags();

    // R7: all enables off, all events
    en_alarm = 1'b0;
    alm_sec = 8'h10;
    pulse(1'b1, 1'b1, 1'b0);
    chk("R7 latched without enables", flag_reg, 8'h70);
    chk("R7 irq idle", {7'd0, irq_n}, 8'h01);
    repeat (3) @(negedge clk);
    chk("R7 still held", flag_reg, 8'h70);
    // R8 enabling afterwards asserts summary
    en_periodic = 1'b1;
    #1;
    chk("R8 summary via periodic", flag_reg, 8'hF0);
    chk("R8 irq low", {7'd0, irq_n}, 8'h00);
    en_periodic = 1'b0; en_update = 1'b1;
    #1;
    chk("R8 summary via update", flag_reg, 8'hF0);
    en_update = 1'b0;
    #1;
    chk("R8 summary off", flag_reg, 8'h70);

    // R9 read returns contents then clears
    en_alarm = 1'b1;
    @(negedge clk);
    flag_rd = 1'b1;
    #1;
    chk("R9 read value", flag_reg, 8'hF0);
    @(negedge clk);
    flag_rd = 1'b0;
    chk("R9 cleared", flag_reg, 8'h00);
    chk("R9 irq released", {7'd0, irq_n}, 8'h01);

    // R10 event during read
    pulse(1'b0, 1'b1, 1'b0);
    chk("R10 setup", flag_reg, 8'hB0);
    pulse(1'b1, 1'b0, 1'b1);
    chk("R10 periodic survives read", flag_reg, 8'h40);
    en_alarm = 1'b0; en_periodic = 1'b1;
    pulse(1'b0, 1'b1, 1'b1);
    chk("R10 update+alarm survive read", flag_reg, 8'h30);
    chk("R11 low nibble", {4'h0, flag_reg[3:0]}, 8'h00);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule